// File: doc/BRIEF.md
# Serial Transmitter Sharing a Port Pin

This block drives one serial output pin that doubles as a general-purpose port bit. While the transmit enable is low, the port data and port direction inputs set the pin's level and output enable, and the transmit logic is held in its initial state. While the enable is high, the transmitter owns the pin. It shows the mark level (1) when idle and shifts out frames built from a one-entry holding register.

Frames advance on a one-cycle bit strobe supplied from outside. In asynchronous mode a frame is a start bit, the data bits, an optional parity bit and one or two stop bits. In synchronous mode a frame is the data bits alone. In synchronous mode, any of three receive error flags stops a new frame from starting. Dropping the enable aborts whatever is in progress in the same cycle. Software can therefore send a break by setting the port level to 0, keeping the port direction as output, and then clearing the enable.

Top module: `tx_port_share`

## Requirements
- R1: While `tx_en_i` is 0, `pin_o` equals `port_dr_i` and `pin_oe_o` equals `port_ddr_i`, combinationally.
- R2: While `tx_en_i` is 1, `pin_oe_o` is 1, and `pin_o` is 1 whenever no frame is being shifted.
- R3: A low `tx_en_i` hands the pin to the port inputs in the same cycle and aborts any frame. From the next cycle on, `tdr_empty_o` and `tx_end_o` read 1. A later rise of `tx_en_i` leaves the pin at mark level and does not resume the aborted frame.
- R4: A pulse on `wr_i` while `tx_en_i` is 1 stores `wr_data_i` and drives `tdr_empty_o` to 0 from the next cycle. A pulse on `wr_i` while `tx_en_i` is 0 is ignored: no frame follows after the enable is raised.
- R5: When `tdr_empty_o` is 0, no frame is active and starting is allowed, the holding register is copied into the shifter at the next `bit_tick_i`. From the next cycle, `tdr_empty_o` reads 1 and `pin_o` carries the first frame bit.
- R6: With `sync_mode_i` = 0, the pin carries these bits, in order: a 0 start bit; the DW data bits, LSB first; a parity bit when `par_en_i` = 1; then 1 stop bit, or 2 stop bits when `two_stop_i` = 1. The parity bit is the XOR of the data, inverted when `par_odd_i` = 1. Each bit holds from one tick to the next.
- R7: With `sync_mode_i` = 1, a frame is the DW data bits LSB first, with no start, parity or stop bits.
- R8: With `sync_mode_i` = 1, a frame cannot start while any of `err_overrun_i`, `err_parity_i` or `err_frame_i` is 1. It starts at the first tick after all three are 0. With `sync_mode_i` = 0, these flags have no effect.
- R9: `tx_end_o` is 1 exactly when no frame is active and `tdr_empty_o` is 1. If data was written during a frame, the next frame's first bit follows the last bit at the very next tick, with no idle bit between.
- R10: Setting `port_dr_i` = 0 with `port_ddr_i` = 1 and then clearing `tx_en_i` in mid-frame drives `pin_o` to 0 with `pin_oe_o` = 1 (break).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One-cycle strobe per bit period |
| tx_en_i | input | 1 | Transmit enable; 0 gives the pin to the port inputs |
| port_dr_i | input | 1 | Port output level used while disabled |
| port_ddr_i | input | 1 | Port direction (1 = drive) used while disabled |
| wr_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | DW | Data to transmit |
| sync_mode_i | input | 1 | 0 = framed asynchronous, 1 = synchronous data only |
| par_en_i | input | 1 | Append a parity bit (asynchronous) |
| par_odd_i | input | 1 | Odd parity when 1 |
| two_stop_i | input | 1 | Two stop bits when 1 |
| err_overrun_i | input | 1 | Receive overrun flag |
| err_parity_i | input | 1 | Receive parity error flag |
| err_frame_i | input | 1 | Receive framing error flag |
| tdr_empty_o | output | 1 | Holding register empty |
| tx_end_o | output | 1 | Transmitter idle with nothing pending |
| pin_o | output | 1 | Pin output level |
| pin_oe_o | output | 1 | Pin output enable |

## Verification
A bad frame counter or shift register shows up in the very next bit period. The pin carries a wrong or misplaced bit, or a stop or parity bit is missing, so it is visible on the first frame of the affected configuration. A holding register flag stuck at the wrong value shows one tick later: either a frame never starts, or a stale frame repeats. A gate that ignores the error flags starts a frame at the first tick it should have blocked. An abort path that fails to clear state shows as a resumed frame right after the enable is raised again.

// File: rtl/tx_pkg.sv
package tx_pkg;
  typedef enum logic {
    FRAME_ASYNC = 1'b0,
    FRAME_SYNC  = 1'b1
  } frame_mode_e;

  typedef struct packed {
    logic overrun;
    logic parity;
    logic framing;
  } rx_err_t;
endpackage

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          load_i,
  output logic [DW-1:0] data_o,
  output logic          empty_o
);
  logic [DW-1:0] data_q;
  logic          empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      empty_q <= 1'b1;
    end else if (!en_i) begin
      empty_q <= 1'b1;
    end else if (wr_i) begin
      data_q  <= wr_data_i;
      empty_q <= 1'b0;
    end else if (load_i) begin
      empty_q <= 1'b1;
    end
  end

  assign data_o  = data_q;
  assign empty_o = empty_q;
endmodule

// File: rtl/tx_shift.sv
module tx_shift
  import tx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          ready_i,
  input  logic [DW-1:0] data_i,
  input  frame_mode_e   mode_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  input  logic          two_stop_i,
  output logic          load_o,
  output logic          busy_o,
  output logic          bit_o
);
  localparam int FW = DW + 4;
  localparam int CW = $clog2(FW + 1);

  logic [FW-1:0] frame_q, nxt_frame;
  logic [CW-1:0] cnt_q, nxt_len;
  logic          busy_q, last;

  always_comb begin
    nxt_frame = '1;
    nxt_len   = CW'(DW);
    if (mode_i == FRAME_SYNC) begin
      nxt_frame[DW-1:0] = data_i;
    end else begin
      nxt_frame[0]    = 1'b0;
      nxt_frame[DW:1] = data_i;
      if (par_en_i) nxt_frame[DW+1] = (^data_i) ^ par_odd_i;
      nxt_len = CW'(DW + 2) + CW'(par_en_i) + CW'(two_stop_i);
    end
  end

  assign last   = busy_q && (cnt_q == CW'(1));
  assign load_o = en_i && tick_i && ready_i && (!busy_q || last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '1;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
    end else if (!en_i) begin
      frame_q <= '1;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
    end else if (load_o) begin
      frame_q <= nxt_frame;
      cnt_q   <= nxt_len;
      busy_q  <= 1'b1;
    end else if (tick_i && busy_q) begin
      if (last) begin
        busy_q <= 1'b0;
      end else begin
        frame_q <= {1'b1, frame_q[FW-1:1]};
        cnt_q   <= cnt_q - 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign bit_o  = frame_q[0];
endmodule

// File: rtl/tx_pin_sel.sv
module tx_pin_sel (
  input  logic en_i,
  input  logic dr_i,
  input  logic ddr_i,
  input  logic busy_i,
  input  logic bit_i,
  output logic pin_o,
  output logic oe_o
);
  always_comb begin
    if (en_i) begin
      oe_o  = 1'b1;
      pin_o = busy_i ? bit_i : 1'b1;
    end else begin
      oe_o  = ddr_i;
      pin_o = dr_i;
    end
  end
endmodule

// File: rtl/tx_port_share.sv
module tx_port_share
  import tx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_tick_i,
  input  logic          tx_en_i,
  input  logic          port_dr_i,
  input  logic          port_ddr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          sync_mode_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  input  logic          two_stop_i,
  input  logic          err_overrun_i,
  input  logic          err_parity_i,
  input  logic          err_frame_i,
  output logic          tdr_empty_o,
  output logic          tx_end_o,
  output logic          pin_o,
  output logic          pin_oe_o
);
  frame_mode_e   mode;
  rx_err_t       errs;
  logic [DW-1:0] hold_data;
  logic          hold_empty, load, busy, sh_bit, start_ok;

  assign mode     = frame_mode_e'(sync_mode_i);
  assign errs     = '{overrun: err_overrun_i, parity: err_parity_i, framing: err_frame_i};
  // sync mode: any receive error holds off a new frame
  assign start_ok = !hold_empty && ((mode == FRAME_ASYNC) || (errs == '0));

  tx_hold_reg #(.DW(DW)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (tx_en_i),
    .wr_i      (wr_i),
    .wr_data_i (wr_data_i),
    .load_i    (load),
    .data_o    (hold_data),
    .empty_o   (hold_empty)
  );

  tx_shift #(.DW(DW)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (tx_en_i),
    .tick_i     (bit_tick_i),
    .ready_i    (start_ok),
    .data_i     (hold_data),
    .mode_i     (mode),
    .par_en_i   (par_en_i),
    .par_odd_i  (par_odd_i),
    .two_stop_i (two_stop_i),
    .load_o     (load),
    .busy_o     (busy),
    .bit_o      (sh_bit)
  );

  tx_pin_sel u_pin (
    .en_i   (tx_en_i),
    .dr_i   (port_dr_i),
    .ddr_i  (port_ddr_i),
    .busy_i (busy),
    .bit_i  (sh_bit),
    .pin_o  (pin_o),
    .oe_o   (pin_oe_o)
  );

  assign tdr_empty_o = hold_empty;
  assign tx_end_o    = !busy && hold_empty;
endmodule

// File: rtl/tx_port_share_chk.sv
module tx_port_share_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_en_i,
  input logic wr_i,
  input logic sync_mode_i,
  input logic err_overrun_i,
  input logic err_parity_i,
  input logic err_frame_i,
  input logic tdr_empty_o,
  input logic tx_end_o,
  input logic pin_o,
  input logic pin_oe_o
);
  AST_DISABLE_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> tdr_empty_o && tx_end_o);  // R3

  AST_WRITE_FILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_i && wr_i |=> !tdr_empty_o);  // R4

  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tdr_empty_o) && $past(tx_en_i) && tx_en_i && !$past(sync_mode_i) && !wr_i
    |-> !pin_o);  // R6

  AST_SYNC_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_i && sync_mode_i && (err_overrun_i || err_parity_i || err_frame_i) && !tdr_empty_o
    |=> !tdr_empty_o);  // R8

  AST_IDLE_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_i && tx_end_o |-> pin_o && pin_oe_o);  // R9
endmodule

bind tx_port_share tx_port_share_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tx_en_i       (tx_en_i),
  .wr_i          (wr_i),
  .sync_mode_i   (sync_mode_i),
  .err_overrun_i (err_overrun_i),
  .err_parity_i  (err_parity_i),
  .err_frame_i   (err_frame_i),
  .tdr_empty_o   (tdr_empty_o),
  .tx_end_o      (tx_end_o),
  .pin_o         (pin_o),
  .pin_oe_o      (pin_oe_o)
);

// File: tb/sim_tx_port_share.sv
module sim_tx_port_share;
  localparam int CLK_P = 10;
  localparam int DW    = 8;
  localparam int FW    = DW + 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          bit_tick_i = 1'b0, tx_en_i = 1'b0, port_dr_i = 1'b1, port_ddr_i = 1'b0;
  logic          wr_i = 1'b0;
  logic [DW-1:0] wr_data_i = '0;
  logic          sync_mode_i = 1'b0, par_en_i = 1'b0, par_odd_i = 1'b0, two_stop_i = 1'b0;
  logic          err_overrun_i = 1'b0, err_parity_i = 1'b0, err_frame_i = 1'b0;
  logic          tdr_empty_o, tx_end_o, pin_o, pin_oe_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  tx_port_share #(.DW(DW)) u0 (.*);

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (ok !== 1'b1) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i) bit_tick_i = 1'b1;
    @(negedge clk_i) bit_tick_i = 1'b0;
  endtask

  task automatic write(input logic [DW-1:0] d);
    @(negedge clk_i) begin wr_i = 1'b1; wr_data_i = d; end
    @(negedge clk_i) wr_i = 1'b0;
  endtask

  function automatic logic [FW-1:0] exp_async(input logic [DW-1:0] d, input logic pe, input logic po);
    logic [FW-1:0] v;
    v = '1;
    v[0] = 1'b0;
    for (int i = 0; i < DW; i++) v[i+1] = d[i];
    if (pe) v[DW+1] = ((^d) ^ po);
    return v;
  endfunction

  task automatic run_async(input logic [DW-1:0] d, input logic pe, input logic po, input logic ts);
    logic [FW-1:0] got, exp;
    int len;
    @(negedge clk_i) begin sync_mode_i = 1'b0; par_en_i = pe; par_odd_i = po; two_stop_i = ts; end
    len = DW + 2 + int'(pe) + int'(ts);
    exp = exp_async(d, pe, po);
    got = '1;
    write(d);
    chk(!tdr_empty_o, "R4 write clears empty", int'(tdr_empty_o), 0);
    for (int i = 0; i < len; i++) begin
      tick();
      got[i] = pin_o;
      if (i == 0) begin
        chk(tdr_empty_o && !tx_end_o, "R5/R9 load at tick", int'({tdr_empty_o, tx_end_o}), 2);
        chk(pin_oe_o, "R2 oe while enabled", int'(pin_oe_o), 1);
      end
    end
    chk(got == exp, "R6 async frame bits", int'(got), int'(exp));
    tick();
    chk(pin_o && tx_end_o, "R9 idle mark after frame", int'({pin_o, tx_end_o}), 3);
  endtask

  task automatic run_sync(input logic [DW-1:0] d);
    logic [DW-1:0] got;
    @(negedge clk_i) sync_mode_i = 1'b1;
    write(d);
    for (int i = 0; i < DW; i++) begin
      tick();
      got[i] = pin_o;
    end
    chk(got == d, "R7 sync frame bits", int'(got), int'(d));
    tick();
    chk(pin_o && tx_end_o, "R7 sync idle after frame", int'({pin_o, tx_end_o}), 3);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [FW-1:0] got, exp;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // reset / port mode
    chk(tdr_empty_o && tx_end_o, "R3 reset state", int'({tdr_empty_o, tx_end_o}), 3);
    chk(pin_o == 1'b1 && pin_oe_o == 1'b0, "R1 port follow", int'({pin_o, pin_oe_o}), 2);
    port_dr_i = 1'b0; port_ddr_i = 1'b1; #1;
    chk(pin_o == 1'b0 && pin_oe_o == 1'b1, "R1 port follow low", int'({pin_o, pin_oe_o}), 1);
    @(negedge clk_i) begin port_dr_i = 1'b1; port_ddr_i = 1'b1; tx_en_i = 1'b1; end
    #1;
    chk(pin_o && pin_oe_o, "R2 idle mark", int'({pin_o, pin_oe_o}), 3);

    // exhaustive async sweep over data and all frame options
    for (int cfg = 0; cfg < 8; cfg++)
      for (int d = 0; d < (1 << DW); d++)
        run_async(DW'(d), cfg[0], cfg[1], cfg[2]);

    // exhaustive sync sweep
    for (int d = 0; d < (1 << DW); d++) run_sync(DW'(d));

    // back-to-back frames
    @(negedge clk_i) begin sync_mode_i = 1'b0; par_en_i = 1'b0; two_stop_i = 1'b0; end
    write(8'hC3);
    tick();
    write(8'h5E);
    for (int i = 1; i < DW + 2; i++) tick();
    tick();
    chk(!pin_o && tdr_empty_o && !tx_end_o, "R9 back-to-back start",
        int'({pin_o, tdr_empty_o, tx_end_o}), 2);
    got = '1; got[0] = pin_o;
    for (int i = 1; i < DW + 2; i++) begin tick(); got[i] = pin_o; end
    exp = exp_async(8'h5E, 1'b0, 1'b0);
    chk(got == exp, "R9 second frame bits", int'(got), int'(exp));
    tick();

    // sync start gate, each error flag
    for (int e = 0; e < 3; e++) begin
      @(negedge clk_i) begin
        sync_mode_i = 1'b1;
        err_overrun_i = (e == 0); err_parity_i = (e == 1); err_frame_i = (e == 2);
      end
      write(8'h6D);
      repeat (3) tick();
      chk(pin_o && !tdr_empty_o, "R8 blocked by error", int'({pin_o, tdr_empty_o}), 2);
      @(negedge clk_i) begin err_overrun_i = 1'b0; err_parity_i = 1'b0; err_frame_i = 1'b0; end
      tick();
      chk(pin_o == 1'b1 && tdr_empty_o, "R8 starts when clear", int'({pin_o, tdr_empty_o}), 3);
      repeat (DW) tick();
    end
    // async ignores error flags
    @(negedge clk_i) begin sync_mode_i = 1'b0; err_parity_i = 1'b1; end
    write(8'h81);
    tick();
    chk(!pin_o && tdr_empty_o, "R8 async ignores errors", int'({pin_o, tdr_empty_o}), 1);
    repeat (DW + 2) tick();
    @(negedge clk_i) err_parity_i = 1'b0;

    // break by abort mid-frame
    write(8'hA5);
    tick();
    tick();
    chk(pin_o == 1'b1, "R6 bit0 before abort", int'(pin_o), 1);
    @(negedge clk_i) begin port_dr_i = 1'b0; port_ddr_i = 1'b1; end
    #1;
    chk(pin_o == 1'b1, "R3 port level hidden while enabled", int'(pin_o), 1);
    @(negedge clk_i) tx_en_i = 1'b0;
    #1;
    chk(!pin_o && pin_oe_o, "R10 break driven low", int'({pin_o, pin_oe_o}), 1);
    @(negedge clk_i);
    chk(tdr_empty_o && tx_end_o, "R3 abort clears state", int'({tdr_empty_o, tx_end_o}), 3);
    write(8'h00);
    chk(tdr_empty_o, "R4 write ignored when disabled", int'(tdr_empty_o), 1);
    @(negedge clk_i) begin port_dr_i = 1'b1; port_ddr_i = 1'b0; end
    #1;
    chk(pin_o && !pin_oe_o, "R1 port input mode", int'({pin_o, pin_oe_o}), 2);
    @(negedge clk_i) begin port_ddr_i = 1'b1; tx_en_i = 1'b1; end
    for (int i = 0; i < 4; i++) begin
      tick();
      chk(pin_o && tdr_empty_o, "R3/R4 no resume after enable", int'({pin_o, tdr_empty_o}), 3);
    end

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule